// File: doc/BRIEF.md
# Repeated-Preamble Packet Detector

This block monitors a qualified stream of complex baseband samples and signals the start of a packet whose preamble is made of a short pattern repeated many times. Each accepted sample is multiplied by the complex conjugate of the sample taken exactly one pattern period earlier. The products are summed over a sliding window that spans several periods. A received signal that repeats gives a large, stable sum. Noise gives a small one.

The magnitude of the windowed sum is approximated as |Re|+|Im|, so no square root is needed. This magnitude is compared with a programmable threshold. A one-cycle detect pulse is raised only once the metric has stayed above the threshold for a programmable number of consecutive accepted samples. After a pulse the block stays silent until it is re-armed. With the default parameters (one period of 16 samples, a window of 48 samples), a 20 MHz stream covers a 0.8 µs pattern and a window of three periods.

Top module: `rep_corr_detector`

## Requirements
- R1: After reset, `detect` is 0 and `corrMag` is 0. The delay line and the window history hold zeros, so every sample accepted later sees zeros where no earlier sample exists.
- R2: For each accepted sample x[n] = I+jQ, the product is x[n]·conj(x[n−LAG]). Its real part is I·Id+Q·Qd and its imaginary part is Q·Id−I·Qd, where Id and Qd belong to the sample accepted LAG accepted samples earlier (LAG=16).
- R3: The correlation sum is the exact sum of the products of the last WIN accepted samples (WIN=48). It does not overflow, even for full-scale inputs such as I=Q=−2048 on every sample.
- R4: `corrMag` is the unsigned value |Re(sum)|+|Im(sum)|. It shows the sum that includes a sample from the clock edge that accepts that sample onward.
- R5: A cycle with `sampleValid` low changes neither `corrMag` nor the persistence state, and raises no `detect`.
- R6: An accepted sample counts as above threshold only when its `corrMag` is strictly greater than the unsigned `threshold`; equality does not count. Each above sample adds one to a run counter, which saturates at its maximum. Any accepted sample that is not above clears the counter to zero.
- R7: `detect` is a single-cycle pulse. It is raised one clock edge after the `corrMag` update of the accepted sample whose run count first reaches `persist`, provided the block is armed. A `persist` of 0 acts as 1.
- R8: After a pulse, no further pulse occurs until `rearm` is asserted. Re-arming leaves the run counter unchanged, so the next above sample whose count is at least `persist` fires again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleValid | input | 1 | Qualifies sampleI/sampleQ in this cycle |
| sampleI | input | 12 | In-phase sample, signed |
| sampleQ | input | 12 | Quadrature sample, signed |
| threshold | input | 32 | Unsigned metric threshold |
| persist | input | 8 | Required run length of above-threshold samples |
| rearm | input | 1 | Re-enables detection after a pulse |
| detect | output | 1 | One-cycle packet detect pulse |
| corrMag | output | 32 | Correlation magnitude \|Re\|+\|Im\|, unsigned |

## Verification
`corrMag` reflects a sample one clock edge after that sample is accepted. Any detect decision caused by that sample appears one edge later still. The bench drives inputs on the falling edge and spaces samples two cycles apart. It reads `corrMag` at the first falling edge after the accepting edge and `detect` at the second. Its reference model computes the window sum directly from the stored sample history and tracks the run count and arming state, so every sample is checked against a value computed independently.

// File: rtl/corr_pkg.sv
`timescale 1ns/1ps
package corr_pkg;
  // Strobes from the control path to the datapath.
  typedef struct packed {
    logic shift;  // accept the current sample: advance delay line and window
  } corrStrobe_t;
endpackage

// File: rtl/corr_datapath.sv
`timescale 1ns/1ps
module corr_datapath
  import corr_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int LAG      = 16,
  parameter int WIN      = 48,
  localparam int PROD_W  = 2*SAMPLE_W + 1,
  localparam int ACC_W   = PROD_W + $clog2(WIN),
  localparam int MAG_W   = ACC_W + 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  corrStrobe_t                strobe,
  input  logic signed [SAMPLE_W-1:0] sampleI,
  input  logic signed [SAMPLE_W-1:0] sampleQ,
  output logic        [MAG_W-1:0]    corrMag
);
  localparam int EXT_W = ACC_W + 1 - PROD_W;

  logic signed [SAMPLE_W-1:0] dlyI [LAG];
  logic signed [SAMPLE_W-1:0] dlyQ [LAG];
  logic signed [PROD_W-1:0]   winRe [WIN];
  logic signed [PROD_W-1:0]   winIm [WIN];
  logic signed [PROD_W-1:0]   curI, curQ, oldI, oldQ;
  logic signed [PROD_W-1:0]   prodRe, prodIm;
  logic signed [ACC_W-1:0]    accRe, accIm;
  logic        [ACC_W:0]      accWideRe, accWideIm;
  logic        [ACC_W-1:0]    absRe, absIm;

  // Conjugate product of the new sample with the one a period back
  always_comb begin
    curI   = PROD_W'(sampleI);
    curQ   = PROD_W'(sampleQ);
    oldI   = PROD_W'(dlyI[LAG-1]);
    oldQ   = PROD_W'(dlyQ[LAG-1]);
    prodRe = curI*oldI + curQ*oldQ;
    prodIm = curQ*oldI - curI*oldQ;
  end

  // Delay line of one pattern period
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < LAG; k++) begin
        dlyI[k] <= '0;
        dlyQ[k] <= '0;
      end
    end else if (strobe.shift) begin
      dlyI[0] <= sampleI;
      dlyQ[0] <= sampleQ;
      for (int k = 1; k < LAG; k++) begin
        dlyI[k] <= dlyI[k-1];
        dlyQ[k] <= dlyQ[k-1];
      end
    end
  end

  // History of products inside the window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < WIN; k++) begin
        winRe[k] <= '0;
        winIm[k] <= '0;
      end
    end else if (strobe.shift) begin
      winRe[0] <= prodRe;
      winIm[0] <= prodIm;
      for (int k = 1; k < WIN; k++) begin
        winRe[k] <= winRe[k-1];
        winIm[k] <= winIm[k-1];
      end
    end
  end

  // Running sum: add entering product, drop leaving one
  always_comb begin
    accWideRe = {accRe[ACC_W-1], accRe}
              + {{EXT_W{prodRe[PROD_W-1]}}, prodRe}
              - {{EXT_W{winRe[WIN-1][PROD_W-1]}}, winRe[WIN-1]};
    accWideIm = {accIm[ACC_W-1], accIm}
              + {{EXT_W{prodIm[PROD_W-1]}}, prodIm}
              - {{EXT_W{winIm[WIN-1][PROD_W-1]}}, winIm[WIN-1]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accRe <= '0;
      accIm <= '0;
    end else if (strobe.shift) begin
      accRe <= accWideRe[ACC_W-1:0];
      accIm <= accWideIm[ACC_W-1:0];
    end
  end

  always_comb begin
    absRe   = accRe[ACC_W-1] ? $unsigned(-accRe) : $unsigned(accRe);
    absIm   = accIm[ACC_W-1] ? $unsigned(-accIm) : $unsigned(accIm);
    corrMag = {1'b0, absRe} + {1'b0, absIm};
  end

  // R3: the running sum never leaves the accumulator range
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shift |-> (accWideRe[ACC_W] == accWideRe[ACC_W-1]) &&
                     (accWideIm[ACC_W] == accWideIm[ACC_W-1]));

  // R5: without an accepted sample the sum holds
  p_hold_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.shift |=> $stable(accRe) && $stable(accIm));
endmodule

// File: rtl/corr_control.sv
`timescale 1ns/1ps
module corr_control
  import corr_pkg::*;
#(
  parameter int MAG_W = 32,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleValid,
  input  logic             rearm,
  input  logic [MAG_W-1:0] threshold,
  input  logic [CNT_W-1:0] persist,
  input  logic [MAG_W-1:0] corrMag,
  output corrStrobe_t      strobe,
  output logic             detect
);
  logic             freshQ;   // corrMag holds a just-accepted sample
  logic             armed;
  logic             above;
  logic             fire;
  logic [CNT_W-1:0] runCnt;
  logic [CNT_W-1:0] runNext;

  assign strobe.shift = sampleValid;

  always_comb begin
    above   = corrMag > threshold;
    runNext = (runCnt == {CNT_W{1'b1}}) ? runCnt : runCnt + 1'b1;
    fire    = freshQ && above && armed && (runNext >= persist);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      freshQ <= 1'b0;
      runCnt <= '0;
      armed  <= 1'b1;
      detect <= 1'b0;
    end else begin
      freshQ <= sampleValid;
      detect <= fire;
      if (freshQ) runCnt <= above ? runNext : '0;
      if (rearm)     armed <= 1'b1;
      else if (fire) armed <= 1'b0;
    end
  end

  // R6: a sample at or under the threshold empties the run
  p_count_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    freshQ && !above |=> runCnt == '0);

  // R7: a pulse only follows a run that reached the programmed length
  p_detect_reached_r7: assert property (@(posedge clk) disable iff (!rstN)
    detect |-> (runCnt != '0) && (runCnt >= $past(persist)));

  // R8: disarmed and not re-armed means no pulse
  p_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    !armed && !rearm |=> !detect);
endmodule

// File: rtl/rep_corr_detector.sv
`timescale 1ns/1ps
module rep_corr_detector
  import corr_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int LAG      = 16,
  parameter int WIN      = 48,
  parameter int CNT_W    = 8,
  localparam int MAG_W   = 2*SAMPLE_W + 1 + $clog2(WIN) + 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sampleValid,
  input  logic signed [SAMPLE_W-1:0] sampleI,
  input  logic signed [SAMPLE_W-1:0] sampleQ,
  input  logic        [MAG_W-1:0]    threshold,
  input  logic        [CNT_W-1:0]    persist,
  input  logic                       rearm,
  output logic                       detect,
  output logic        [MAG_W-1:0]    corrMag
);
  corrStrobe_t strobe;

  corr_control #(.MAG_W(MAG_W), .CNT_W(CNT_W)) i_control (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .rearm(rearm),
    .threshold(threshold), .persist(persist), .corrMag(corrMag),
    .strobe(strobe), .detect(detect)
  );

  corr_datapath #(.SAMPLE_W(SAMPLE_W), .LAG(LAG), .WIN(WIN)) i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .sampleI(sampleI), .sampleQ(sampleQ), .corrMag(corrMag)
  );
endmodule

// File: tb/test_rep_corr_detector.sv
`timescale 1ns/1ps
module test_rep_corr_detector;
  localparam int LAG = 16;
  localparam int WIN = 48;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleValid = 1'b0;
  logic signed [11:0] sampleI = '0;
  logic signed [11:0] sampleQ = '0;
  logic [31:0] threshold = '1;
  logic [7:0]  persist = 8'd1;
  logic        rearm = 1'b0;
  logic        detect;
  logic [31:0] corrMag;

  int checks = 0;
  int failures = 0;

  // reference state
  int     hI [LAG];
  int     hQ [LAG];
  longint pRe [WIN];
  longint pIm [WIN];
  longint expMag;
  int     runCnt;
  bit     armed;
  bit     expDet;
  int     pulses;

  always #5 clk = ~clk;

  rep_corr_detector i_rep_corr_detector (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .sampleI(sampleI), .sampleQ(sampleQ), .threshold(threshold),
    .persist(persist), .rearm(rearm), .detect(detect), .corrMag(corrMag)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic modelClear();
    for (int k = 0; k < LAG; k++) begin hI[k] = 0; hQ[k] = 0; end
    for (int k = 0; k < WIN; k++) begin pRe[k] = 0; pIm[k] = 0; end
    expMag = 0; runCnt = 0; armed = 1; expDet = 0; pulses = 0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; sampleValid = 1'b0; rearm = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    modelClear();
    @(negedge clk);
  endtask

  // One accepted sample, then check magnitude and detect at their due cycles
  task automatic sendSample(input int i, input int q, input string tag);
    longint sr, si, re, im;
    int need;
    sampleI = 12'(i); sampleQ = 12'(q); sampleValid = 1'b1;
    @(negedge clk);
    sampleValid = 1'b0;
    sampleI = 12'(i * 7 + 3); sampleQ = 12'(q - 5);
    re = longint'(i) * hI[LAG-1] + longint'(q) * hQ[LAG-1];
    im = longint'(q) * hI[LAG-1] - longint'(i) * hQ[LAG-1];
    for (int k = LAG-1; k > 0; k--) begin hI[k] = hI[k-1]; hQ[k] = hQ[k-1]; end
    hI[0] = i; hQ[0] = q;
    for (int k = WIN-1; k > 0; k--) begin pRe[k] = pRe[k-1]; pIm[k] = pIm[k-1]; end
    pRe[0] = re; pIm[0] = im;
    sr = 0; si = 0;
    for (int k = 0; k < WIN; k++) begin sr += pRe[k]; si += pIm[k]; end
    expMag = (sr < 0 ? -sr : sr) + (si < 0 ? -si : si);
    chk({tag, " corrMag R4"}, longint'(corrMag), expMag);
    if (expMag > longint'(threshold)) begin
      if (runCnt < 255) runCnt++;
    end else runCnt = 0;
    need = (persist == 0) ? 1 : int'(persist);
    expDet = (runCnt != 0) && armed && (runCnt >= need);
    if (expDet) armed = 0;
    @(negedge clk);
    chk({tag, " detect R7"}, longint'(detect), longint'(expDet));
    if (detect) pulses++;
  endtask

  task automatic pulseRearm();
    rearm = 1'b1;
    @(negedge clk);
    rearm = 1'b0;
    armed = 1;
    chk("rearm cycle detect R8", longint'(detect), 0);
    @(negedge clk);
  endtask

  task automatic t_reset();
    doReset();
    chk("reset corrMag R1", longint'(corrMag), 0);
    chk("reset detect R1", longint'(detect), 0);
    // first sample sees zero history: product is zero
    threshold = '1;
    sendSample(1000, -700, "first sample R1");
    chk("first sample zero R1", longint'(corrMag), 0);
  endtask

  task automatic t_constant();
    doReset();
    threshold = '1; persist = 8'd1;
    for (int n = 0; n < LAG + WIN + 6; n++) sendSample(300, -200, "constant R2 R3");
    chk("constant steady R3", longint'(corrMag), 48 * 130000);
  endtask

  task automatic t_rotating();
    int bi, bq, ri, rq, t;
    doReset();
    threshold = '1;
    for (int n = 0; n < 90; n++) begin
      bi = ((n % LAG) * 97) % 1500 - 700;
      bq = ((n % LAG) * 53) % 1100 - 500;
      ri = bi; rq = bq;
      for (int r = 0; r < (n / LAG) % 4; r++) begin t = ri; ri = -rq; rq = t; end
      sendSample(ri, rq, "rotating R2");
    end
  endtask

  task automatic t_fullscale();
    doReset();
    threshold = '1;
    for (int n = 0; n < LAG + WIN + 2; n++) sendSample(-2048, -2048, "fullscale R3");
    chk("fullscale sum R3", longint'(corrMag), 48 * 64'd8388608);
    for (int n = 0; n < 20; n++) sendSample(2047, -2048, "fullscale mixed R3");
  endtask

  task automatic t_idle();
    longint held;
    doReset();
    threshold = 32'd100; persist = 8'd200;
    for (int n = 0; n < 30; n++) sendSample(400, 150, "idle prefill R5");
    held = longint'(corrMag);
    for (int c = 0; c < 12; c++) begin
      sampleI = 12'(c * 111); sampleQ = 12'(-c * 57);
      @(negedge clk);
      chk("idle corrMag R5", longint'(corrMag), held);
      chk("idle detect R5", longint'(detect), 0);
    end
    sendSample(400, 150, "idle resume R5");
  endtask

  task automatic t_persist();
    doReset();
    threshold = 32'd1000000; persist = 8'd5;
    for (int n = 0; n < 70; n++) sendSample(300, -200, "persist R6 R7");
    chk("persist single pulse R7", pulses, 1);
  endtask

  task automatic t_equal();
    doReset();
    threshold = 32'd6240000; persist = 8'd1;
    for (int n = 0; n < LAG + WIN + 10; n++) sendSample(300, -200, "equal R6");
    chk("equal no pulse R6", pulses, 0);
    threshold = 32'd6239999;
    sendSample(300, -200, "one below R6");
    chk("one below fires R6", pulses, 1);
  endtask

  task automatic t_dropout();
    doReset();
    persist = 8'd4; threshold = '1;
    for (int n = 0; n < LAG + WIN; n++) sendSample(300, -200, "dropout fill R6");
    threshold = 32'd1000;
    for (int n = 0; n < 3; n++) sendSample(300, -200, "dropout run R6");
    threshold = '1;
    sendSample(300, -200, "dropout break R6");
    threshold = 32'd1000;
    for (int n = 0; n < 3; n++) sendSample(300, -200, "dropout rerun R6");
    chk("dropout no early pulse R6", pulses, 0);
    sendSample(300, -200, "dropout fourth R6");
    chk("dropout pulse R6", pulses, 1);
  endtask

  task automatic t_rearm();
    doReset();
    threshold = 32'd1000000; persist = 8'd0;
    for (int n = 0; n < 40; n++) sendSample(300, -200, "rearm run R8");
    chk("persist zero acts as one R7", pulses, 1);
    pulseRearm();
    sendSample(300, -200, "rearm refire R8");
    chk("rearm refire R8", pulses, 2);
    for (int n = 0; n < 10; n++) sendSample(300, -200, "rearm quiet R8");
    chk("rearm quiet R8", pulses, 2);
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    modelClear();
    t_reset();
    t_constant();
    t_rotating();
    t_fullscale();
    t_idle();
    t_persist();
    t_equal();
    t_dropout();
    t_rearm();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule